// File: doc/BRIEF.md
# Configurable Asynchronous Serial Character Transmitter

This block takes one parallel character at a time over a valid/ready handshake and shifts it out onto a logic-level asynchronous serial line. Each frame has a low start bit, then the data bits least significant first, then an optional parity bit, then one or two high stop bits. The character length, the parity mode and the stop bit count are selected at run time and captured together with the character, so a frame in flight never changes shape.

Bit timing comes from a base tick enable, nominally pulsing at 115200 per second, divided by a programmable divisor: each bit on the line lasts that many base ticks. Flow control follows the request/clear-to-send pattern. From the moment a character is accepted, the request output is raised. The start bit is launched only once the clear-to-send input has been seen high. After that the frame always runs to completion.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset `txd` is 1, `in_ready` is 1 and `rts` is 0.
- R2: A character is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle until the last stop bit has ended, `in_ready` is 0 and `rts` is 1. `in_ready` returns to 1 and `rts` to 0 in the cycle right after that stop bit ends.
- R3: After acceptance, and while `cts` is 0, `txd` stays 1. The start bit appears in the cycle after the first edge that samples `cts` high.
- R4: The line carries, in order, a start bit of 0, the data bits least significant bit first, the parity bit if any, and the stop bits at 1. Between frames `txd` idles at 1.
- R5: `cfg_len` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Input bits above the selected length are not sent and do not affect parity.
- R6: `cfg_parity` code 0 means no parity bit. Code 1 is even: the bit makes the count of ones in data plus parity even. Code 2 is odd. Code 3 forces the bit to 1 and code 4 forces it to 0. Codes 5 to 7 behave as code 0.
- R7: `cfg_two_stop` = 0 sends one stop bit, and 1 sends two stop bits.
- R8: Each bit lasts `cfg_divisor` base ticks. A divisor of 0 is treated as 1.
- R9: The divisor, length, parity, stop count and data are sampled only at acceptance. Changes during a frame do not affect it.
- R10: Bit timing counts base tick pulses, not clock cycles. With `base_tick` high every other cycle, a bit lasts twice as many clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | Base-rate tick enable, one cycle per pulse |
| cfg_divisor | input | DIV_W | Base ticks per line bit (0 acts as 1) |
| cfg_len | input | LEN_W | Data length code (0..3 gives 5..8 bits) |
| cfg_parity | input | 3 | Parity mode code |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| in_data | input | DATA_W | Character to send |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block can accept a character |
| cts | input | 1 | Peer permits the next character to start |
| rts | output | 1 | Block holds a character to send |
| txd | output | 1 | Serial line, idle high |

## Verification
A wrong frame register or a wrong bit counter shows on `txd` within one bit time. That symptom is a bit of the wrong level at its mid-point, or a frame ending one bit early or late, which then shows up as `in_ready` rising in the wrong cycle. A stuck or misloaded baud counter stretches or shortens the start bit, so it shows from the first bit. The sweep covers every length, parity code and stop count at several data patterns. It samples each bit at mid-bit and checks the exact cycle of the return to ready, so a single wrong level or an off-by-one length is caught in the frame that exposes it.

// File: rtl/uatx_pkg.sv
package uatx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2
    } tx_state_e;

    localparam logic [2:0] PAR_NONE  = 3'd0;
    localparam logic [2:0] PAR_EVEN  = 3'd1;
    localparam logic [2:0] PAR_ODD   = 3'd2;
    localparam logic [2:0] PAR_MARK  = 3'd3;
    localparam logic [2:0] PAR_SPACE = 3'd4;

endpackage

// File: rtl/uatx_framer.sv
module uatx_framer
    import uatx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2,
    parameter int FRAME_W = DATA_W + 4,
    parameter int FL_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data_i,
    input  logic [LEN_W-1:0]   len_code_i,
    input  logic [2:0]         parity_i,
    input  logic               two_stop_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [FL_W-1:0]    frame_len_o
);
    localparam int MIN_BITS = DATA_W - (1 << LEN_W) + 1;

    int   nbits;
    logic xor_acc;
    logic par_bit;
    logic has_par;

    always_comb begin
        nbits   = MIN_BITS + int'(len_code_i);
        xor_acc = 1'b0;
        frame_o = '1;
        frame_o[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nbits) begin
                frame_o[i+1] = data_i[i];
                xor_acc      = xor_acc ^ data_i[i];
            end
        end
        has_par = 1'b1;
        case (parity_i)
            PAR_EVEN:  par_bit = xor_acc;
            PAR_ODD:   par_bit = ~xor_acc;
            PAR_MARK:  par_bit = 1'b1;
            PAR_SPACE: par_bit = 1'b0;
            default: begin
                par_bit = 1'b1;
                has_par = 1'b0;
            end
        endcase
        for (int j = 1; j < FRAME_W; j++) begin
            if (has_par && (j == nbits + 1)) frame_o[j] = par_bit;
        end
        frame_len_o = FL_W'(nbits + 2 + int'(has_par) + int'(two_stop_i));
    end

endmodule

// File: rtl/uatx_baud.sv
module uatx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             bit_end_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } baud_s;

    baud_s            q, d;
    logic [DIV_W-1:0] eff_div;

    always_comb begin
        eff_div   = (div_i == '0) ? DIV_W'(1) : div_i;
        bit_end_o = !clear_i && tick_i && (q.cnt == eff_div - DIV_W'(1));
        d = q;
        if (clear_i)        d.cnt = '0;
        else if (bit_end_o) d.cnt = '0;
        else if (tick_i)    d.cnt = q.cnt + DIV_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < eff_div);

endmodule

// File: rtl/uatx_ctrl.sv
module uatx_ctrl
    import uatx_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int FRAME_W = 12,
    parameter int FL_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid_i,
    input  logic               cts_i,
    input  logic               bit_end_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [FL_W-1:0]    frame_len_i,
    input  logic [DIV_W-1:0]   div_i,
    output logic               in_ready_o,
    output logic               rts_o,
    output logic               txd_o,
    output logic               baud_clear_o,
    output logic [DIV_W-1:0]   div_o
);
    typedef struct packed {
        tx_state_e          st;
        logic [FRAME_W-1:0] frame;
        logic [FL_W-1:0]    left;
        logic [DIV_W-1:0]   div;
    } ctrl_s;

    ctrl_s q, d;

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (in_valid_i) begin
                    d.st    = ST_WAIT;
                    d.frame = frame_i;
                    d.left  = frame_len_i;
                    d.div   = div_i;
                end
            end
            ST_WAIT: begin
                if (cts_i) d.st = ST_SEND;
            end
            ST_SEND: begin
                if (bit_end_i) begin
                    d.frame = {1'b1, q.frame[FRAME_W-1:1]};
                    if (q.left == FL_W'(1)) d.st = ST_IDLE;
                    else                    d.left = q.left - FL_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.frame <= '1;
            q.left  <= '0;
            q.div   <= '0;
        end else begin
            q <= d;
        end
    end

    assign in_ready_o   = (q.st == ST_IDLE);
    assign rts_o        = (q.st != ST_IDLE);
    assign txd_o        = (q.st == ST_SEND) ? q.frame[0] : 1'b1;
    assign baud_clear_o = (q.st != ST_SEND);
    assign div_o        = q.div;

    // R3
    start_after_cts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SEND && $past(q.st) == ST_WAIT) |-> $past(cts_i));

    // R4
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SEND && $past(q.st) == ST_WAIT) |-> (txd_o == 1'b0));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && $past(q.st) != ST_IDLE) |-> $stable(q.div));

    // R2
    ready_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready_o) |-> $past(bit_end_i));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uatx_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic [DIV_W-1:0]  cfg_divisor,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [2:0]        cfg_parity,
    input  logic              cfg_two_stop,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              cts,
    output logic              rts,
    output logic              txd
);
    localparam int FRAME_W = DATA_W + 4;
    localparam int FL_W    = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] frame;
    logic [FL_W-1:0]    frame_len;
    logic               bit_end;
    logic               baud_clear;
    logic [DIV_W-1:0]   div_q;

    uatx_framer #(
        .DATA_W(DATA_W), .LEN_W(LEN_W), .FRAME_W(FRAME_W), .FL_W(FL_W)
    ) u_framer (
        .data_i(in_data), .len_code_i(cfg_len), .parity_i(cfg_parity),
        .two_stop_i(cfg_two_stop), .frame_o(frame), .frame_len_o(frame_len)
    );

    uatx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .clear_i(baud_clear), .tick_i(base_tick),
        .div_i(div_q), .bit_end_o(bit_end)
    );

    uatx_ctrl #(
        .DIV_W(DIV_W), .FRAME_W(FRAME_W), .FL_W(FL_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .cts_i(cts),
        .bit_end_i(bit_end), .frame_i(frame), .frame_len_i(frame_len),
        .div_i(cfg_divisor), .in_ready_o(in_ready), .rts_o(rts), .txd_o(txd),
        .baud_clear_o(baud_clear), .div_o(div_q)
    );

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> txd);

endmodule

// File: tb/sim_uart_frame_tx.sv
module sim_uart_frame_tx;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_tick = 1'b1;
    logic [15:0] cfg_divisor = 16'd2;
    logic [1:0]  cfg_len = 2'd3;
    logic [2:0]  cfg_parity = 3'd0;
    logic        cfg_two_stop = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_valid = 1'b0;
    logic        in_ready, rts, txd;
    logic        cts = 1'b1;
    logic        tick_half = 1'b0;
    int          checks = 0;
    int          errors = 0;

    uart_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .cfg_divisor(cfg_divisor),
        .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .cts(cts), .rts(rts), .txd(txd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) base_tick <= tick_half ? ~base_tick : 1'b1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_frame(input logic [7:0] d, input logic [1:0] l, input logic [2:0] p,
                             input logic two, input logic [15:0] dv, input bit mutate);
        logic e [0:15];
        int   nb, n, b, t;
        logic x;
        nb = 5 + int'(l);
        x  = 1'b0;
        e[0] = 1'b0;
        for (int i = 0; i < nb; i++) begin
            e[1+i] = d[i];
            x = x ^ d[i];
        end
        n = 1 + nb;
        if (p == 3'd1)      begin e[n] = x;    n++; end
        else if (p == 3'd2) begin e[n] = ~x;   n++; end
        else if (p == 3'd3) begin e[n] = 1'b1; n++; end
        else if (p == 3'd4) begin e[n] = 1'b0; n++; end
        e[n] = 1'b1; n++;
        if (two) begin e[n] = 1'b1; n++; end
        b = ((dv == 16'd0) ? 1 : int'(dv)) * (tick_half ? 2 : 1);

        @(negedge clk);
        cfg_len = l; cfg_parity = p; cfg_two_stop = two; cfg_divisor = dv;
        in_data = d; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R2 ready low after accept", int'(in_ready), 0);
        chk(rts == 1'b1, "R2 rts high after accept", int'(rts), 1);
        if (mutate) begin
            cfg_len = ~l; cfg_parity = p + 3'd1; cfg_two_stop = ~two;
            cfg_divisor = dv + 16'd3; in_data = ~d;
        end
        t = 0;
        while (txd !== 1'b0 && t < 100) begin
            @(negedge clk);
            t++;
        end
        repeat (b / 2) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            if (mutate)                chk(txd === e[k], "R9 frame kept after cfg change", int'(txd), int'(e[k]));
            else if (tick_half)        chk(txd === e[k], "R10 bit under slow tick", int'(txd), int'(e[k]));
            else if (dv == 16'd0)      chk(txd === e[k], "R8 divisor zero", int'(txd), int'(e[k]));
            else if (k == 0)           chk(txd === e[k], "R4 start bit", int'(txd), int'(e[k]));
            else if (k <= nb)          chk(txd === e[k], "R5 data bit", int'(txd), int'(e[k]));
            else if (k == nb + 1 && p >= 3'd1 && p <= 3'd4)
                                       chk(txd === e[k], "R6 parity bit", int'(txd), int'(e[k]));
            else                       chk(txd === e[k], "R7 stop bit", int'(txd), int'(e[k]));
            if (k < n - 1) repeat (b) @(negedge clk);
        end
        if (!tick_half) begin
            repeat (b - b / 2 - 1) @(negedge clk);
            chk(in_ready == 1'b0, "R2 busy through last stop", int'(in_ready), 0);
            @(negedge clk);
            chk(in_ready == 1'b1, "R2 ready after last stop", int'(in_ready), 1);
            chk(rts == 1'b0, "R2 rts drop after frame", int'(rts), 0);
            chk(txd == 1'b1, "R4 idle line", int'(txd), 1);
        end else begin
            t = 0;
            while (!in_ready && t < 100) begin
                @(negedge clk);
                t++;
            end
            chk(in_ready == 1'b1, "R10 frame completes", int'(in_ready), 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] pats [0:2];
        pats[0] = 8'hA5; pats[1] = 8'hE0; pats[2] = 8'h3B;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R1 txd idle", int'(txd), 1);
        chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
        chk(rts == 1'b0, "R1 rts low", int'(rts), 0);

        for (int li = 0; li < 4; li++)
            for (int pi = 0; pi < 6; pi++)
                for (int si = 0; si < 2; si++)
                    for (int di = 0; di < 3; di++)
                        run_frame(pats[di], 2'(li), 3'(pi), si[0], 16'd2, 1'b0);

        run_frame(8'h5C, 2'd3, 3'd1, 1'b1, 16'd3, 1'b0);
        run_frame(8'h96, 2'd2, 3'd2, 1'b0, 16'd0, 1'b0);
        run_frame(8'h3C, 2'd3, 3'd6, 1'b0, 16'd4, 1'b0);
        run_frame(8'hC3, 2'd3, 3'd1, 1'b0, 16'd4, 1'b1);
        run_frame(8'h81, 2'd2, 3'd2, 1'b1, 16'd3, 1'b1);

        tick_half = 1'b1;
        run_frame(8'h6D, 2'd3, 3'd1, 1'b1, 16'd3, 1'b0);
        run_frame(8'h12, 2'd0, 3'd3, 1'b0, 16'd4, 1'b0);
        tick_half = 1'b0;
        repeat (3) @(negedge clk);

        cts = 1'b0;
        cfg_len = 2'd3; cfg_parity = 3'd0; cfg_two_stop = 1'b0; cfg_divisor = 16'd2;
        in_data = 8'h00; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        for (int w = 0; w < 20; w++) begin
            @(negedge clk);
            chk(txd == 1'b1, "R3 held while cts low", int'(txd), 1);
            chk(rts == 1'b1, "R3 rts while waiting", int'(rts), 1);
        end
        cts = 1'b1;
        @(negedge clk);
        chk(txd == 1'b0, "R3 start after cts", int'(txd), 0);
        begin
            int t = 0;
            while (!in_ready && t < 100) begin
                @(negedge clk);
                t++;
            end
        end
        chk(in_ready == 1'b1, "R3 frame done after cts", int'(in_ready), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule